// File: doc/BRIEF.md
# Serial EEPROM Write Guard with Block Lock

This block sits between the two-wire slave protocol engine and the 8192-byte array of a serial EEPROM. The engine announces each transfer with a start pulse that carries the two device-select bits of the slave address and the starting byte address. It then delivers data bytes one at a time. The guard decides, byte by byte, whether the array may be written, and it produces the write strobe, address and data for the array.

A 3-bit lock setting reserves a region at the top of the address space. Bytes aimed into that region are dropped without any error. The setting can protect a fixed 64, 128, 256 or 512 bytes, a quarter or a half of the array, or all of it. The lock setting is held in a register of its own. While the hardware protect pin is high, that register cannot be changed.

Successive bytes in a transfer fill one 64-byte page. The address advances inside the page and wraps from its last byte back to its first. Two strap pins give the device its place on a shared bus. A transfer whose select bits differ from the straps writes nothing.

Top module: `eeg_write_guard`

## Requirements
- R1: While reset is held, and just after it, `cfg_o` reads 3'b000 (no protection) and `mem_we_o` is 0.
- R2: The lock code selects the protected top region. 3'b000 protects nothing. 3'b001 protects addresses 8128 and up, 3'b010 protects 8064 and up, 3'b011 protects 7936 and up, and 3'b100 protects 7680 and up. 3'b101 protects 6144 and up, 3'b110 protects 4096 and up, and 3'b111 protects every address. A byte aimed inside the region leaves `mem_we_o` at 0.
- R3: A byte accepted on `wr_byte_i` in cycle N raises `mem_we_o` for exactly cycle N+1, with `mem_addr_o` equal to the current address and `mem_data_o` equal to the byte. `mem_we_o` is never high except in the cycle after an accepted byte.
- R4: The current address is loaded from `start_addr_i` on a start pulse. After every byte, whether written or dropped, bits [5:0] increment and wrap from 63 to 0, while bits [12:6] stay unchanged.
- R5: A pulse on `cfg_wr_i` with `wp_i` low loads `cfg_data_i` into `cfg_o` on the next cycle. With `wp_i` high, `cfg_o` keeps its value.
- R6: A start pulse selects the device only when `sel_bits_i` equals `strap_i`. The bytes of an unselected transfer never raise `mem_we_o`.
- R7: When a lock write and a byte fall in the same cycle, the byte is judged against the lock setting that was in force before that write.
- R8: A byte that arrives in the same cycle as a start pulse is ignored. The address is loaded from the start pulse, and the next byte is written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 2 | Device-select strap pins |
| wp_i | input | 1 | Hardware protect pin; high freezes the lock setting |
| xfer_start_i | input | 1 | Start of a transfer (one-cycle pulse) |
| sel_bits_i | input | 2 | Device-select bits of the slave address |
| start_addr_i | input | 13 | Starting byte address of the transfer |
| wr_byte_i | input | 1 | A data byte is present |
| wr_data_i | input | 8 | Data byte |
| cfg_wr_i | input | 1 | Write request for the lock setting |
| cfg_data_i | input | 3 | New lock code |
| cfg_o | output | 3 | Current lock code |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 13 | Array byte address |
| mem_data_o | output | 8 | Array write data |

## Verification
A lock write and a data byte can fall in the same cycle. A transfer start and a data byte can also coincide. The bench provokes the first case with a byte aimed at the top address while the lock setting changes from none to the whole array. It judges the outcome by whether that byte reaches the array model and whether the following byte is dropped. For the second case, the bench drives a start and a byte together. It expects no strobe in the next cycle, and it expects the next byte to go to the newly loaded address. Random traffic also mixes in combined lock writes, and a final sweep compares the whole array model with the bench's own image of the array.

// File: rtl/eeg_pkg.sv
package eeg_pkg;
  localparam int LOCK_W = 3;

  typedef enum logic [LOCK_W-1:0] {
    LOCK_NONE = 3'd0,
    LOCK_64   = 3'd1,
    LOCK_128  = 3'd2,
    LOCK_256  = 3'd3,
    LOCK_512  = 3'd4,
    LOCK_QTR  = 3'd5,
    LOCK_HALF = 3'd6,
    LOCK_ALL  = 3'd7
  } lock_code_e;
endpackage

// File: rtl/eeg_lock_reg.sv
module eeg_lock_reg
  import eeg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       wp_i,
  input  lock_code_e code_i,
  output lock_code_e code_o
);
  lock_code_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            code_q <= LOCK_NONE;
    else if (wr_i && !wp_i) code_q <= code_i;
  end

  assign code_o = code_q;
endmodule

// File: rtl/eeg_region_decode.sv
module eeg_region_decode
  import eeg_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int FIX_LOG = 6
) (
  input  lock_code_e        code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] ONE   = (ADDR_W+1)'(1);

  logic [ADDR_W:0] size;

  always_comb begin
    unique case (code_i)
      LOCK_NONE: size = '0;
      LOCK_64:   size = ONE << FIX_LOG;
      LOCK_128:  size = ONE << (FIX_LOG + 1);
      LOCK_256:  size = ONE << (FIX_LOG + 2);
      LOCK_512:  size = ONE << (FIX_LOG + 3);
      LOCK_QTR:  size = DEPTH >> 2;
      LOCK_HALF: size = DEPTH >> 1;
      default:   size = DEPTH;
    endcase
  end

  // protected region is [DEPTH-size, DEPTH)
  assign hit_o = (size != '0) && ({1'b0, addr_i} >= (DEPTH - size));
endmodule

// File: rtl/eeg_dev_match.sv
module eeg_dev_match #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] strap_i,
  output logic             match_o
);
  logic match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      match_q <= 1'b0;
    else if (start_i) match_q <= (sel_i == strap_i);
  end

  assign match_o = match_q;
endmodule

// File: rtl/eeg_page_ptr.sv
module eeg_page_ptr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [HI_W-1:0]   hi_q;
  logic [PAGE_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= load_addr_i[ADDR_W-1:PAGE_W];
      lo_q <= load_addr_i[PAGE_W-1:0];
    end else if (step_i) begin
      lo_q <= lo_q + PAGE_W'(1); // wraps inside the page
    end
  end

  assign ptr_o = {hi_q, lo_q};
endmodule

// File: rtl/eeg_write_guard.sv
module eeg_write_guard
  import eeg_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              wp_i,
  input  logic              xfer_start_i,
  input  logic [SEL_W-1:0]  sel_bits_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              wr_byte_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cfg_wr_i,
  input  logic [LOCK_W-1:0] cfg_data_i,
  output logic [LOCK_W-1:0] cfg_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  lock_code_e        code_q;
  logic              sel_q;
  logic              hit;
  logic              step;
  logic [ADDR_W-1:0] ptr_q;

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // start wins over a coincident byte
  assign step = wr_byte_i && !xfer_start_i;

  eeg_lock_reg u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr_i),
    .wp_i   (wp_i),
    .code_i (lock_code_e'(cfg_data_i)),
    .code_o (code_q)
  );

  eeg_dev_match #(.SEL_W(SEL_W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (xfer_start_i),
    .sel_i   (sel_bits_i),
    .strap_i (strap_i),
    .match_o (sel_q)
  );

  eeg_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (xfer_start_i),
    .load_addr_i (start_addr_i),
    .step_i      (step),
    .ptr_o       (ptr_q)
  );

  eeg_region_decode #(.ADDR_W(ADDR_W), .FIX_LOG(PAGE_W)) u_region (
    .code_i (code_q),
    .addr_i (ptr_q),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= step && sel_q && !hit;
      if (step) begin
        addr_q <= ptr_q;
        data_q <= wr_data_i;
      end
    end
  end

  assign cfg_o      = code_q;
  assign mem_we_o   = we_q;
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;
endmodule

// File: rtl/eeg_write_guard_chk.sv
module eeg_write_guard_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_i,
  input logic              xfer_start_i,
  input logic              wr_byte_i,
  input logic              cfg_wr_i,
  input logic [2:0]        cfg_data_i,
  input logic [2:0]        cfg_o,
  input logic              mem_we_o,
  input logic              sel_q,
  input logic [ADDR_W-1:0] ptr_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (cfg_o == 3'b000 && !mem_we_o);
    end
  end

  assert_lock_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_byte_i && cfg_o == 3'b111) |=> !mem_we_o);

  assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_byte_i && !xfer_start_i) |=> !mem_we_o);

  assert_page_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_start_i |=> $stable(ptr_q[ADDR_W-1:PAGE_W]));

  assert_page_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_byte_i && !xfer_start_i) |=>
      ptr_q[PAGE_W-1:0] == $past(ptr_q[PAGE_W-1:0]) + PAGE_W'(1));

  assert_cfg_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> $stable(cfg_o));

  assert_cfg_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !wp_i) |=> cfg_o == $past(cfg_data_i));

  assert_unsel_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_byte_i && !sel_q) |=> !mem_we_o);

  assert_start_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_byte_i && xfer_start_i) |=> !mem_we_o);
endmodule

bind eeg_write_guard eeg_write_guard_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wp_i         (wp_i),
  .xfer_start_i (xfer_start_i),
  .wr_byte_i    (wr_byte_i),
  .cfg_wr_i     (cfg_wr_i),
  .cfg_data_i   (cfg_data_i),
  .cfg_o        (cfg_o),
  .mem_we_o     (mem_we_o),
  .sel_q        (sel_q),
  .ptr_q        (ptr_q)
);

// File: tb/eeg_write_guard_tb_top.sv
`timescale 1ns/1ps
module eeg_write_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [1:0]  strap = 2'd0;
  logic        wp = 1'b0;
  logic        xs = 1'b0;
  logic [1:0]  selb = 2'd0;
  logic [12:0] saddr = '0;
  logic        wb = 1'b0;
  logic [7:0]  wd = '0;
  logic        cw = 1'b0;
  logic [2:0]  cd = '0;
  logic [2:0]  cfg_o;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0]  ram [8192];
  logic [7:0]  exp_ram [8192];
  logic [2:0]  exp_cfg = 3'd0;
  bit          exp_sel = 0;
  logic [12:0] exp_ptr = '0;

  always #2.5 clk = ~clk;

  eeg_write_guard dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap), .wp_i(wp),
    .xfer_start_i(xs), .sel_bits_i(selb), .start_addr_i(saddr),
    .wr_byte_i(wb), .wr_data_i(wd), .cfg_wr_i(cw), .cfg_data_i(cd),
    .cfg_o(cfg_o), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_data;

  function automatic int base_of(input logic [2:0] c);
    case (c)
      3'd1: return 8128;
      3'd2: return 8064;
      3'd3: return 7936;
      3'd4: return 7680;
      3'd5: return 6144;
      3'd6: return 4096;
      3'd7: return 0;
      default: return 8192;
    endcase
  endfunction

  function automatic bit locked(input logic [12:0] a, input logic [2:0] c);
    return int'(a) >= base_of(c);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] s, input logic [12:0] a);
    xs = 1; selb = s; saddr = a;
    @(posedge clk); @(negedge clk);
    xs = 0;
    exp_sel = (s == strap);
    exp_ptr = a;
  endtask

  // one byte; optional lock write in the same cycle
  task automatic do_byte(input logic [7:0] d, input bit c_en, input logic [2:0] c_val,
                         input bit c_wp, input string req);
    bit exp_we;
    wb = 1; wd = d;
    if (c_en) begin cw = 1; cd = c_val; wp = c_wp; end
    exp_we = exp_sel && !locked(exp_ptr, exp_cfg);
    @(posedge clk); @(negedge clk);
    wb = 0; cw = 0;
    chk(mem_we == exp_we, req, int'(mem_we), int'(exp_we));
    if (exp_we) begin
      chk(mem_addr == exp_ptr && mem_data == d, req, int'(mem_addr), int'(exp_ptr));
      exp_ram[exp_ptr] = d;
    end
    exp_ptr[5:0] = exp_ptr[5:0] + 6'd1;
    if (c_en && !c_wp) exp_cfg = c_val;
  endtask

  task automatic do_cfg(input logic [2:0] c, input bit p, input string req);
    cw = 1; cd = c; wp = p;
    @(posedge clk); @(negedge clk);
    cw = 0;
    if (!p) exp_cfg = c;
    chk(cfg_o == exp_cfg, req, int'(cfg_o), int'(exp_cfg));
    wp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    int mism;
    seed = $urandom(32'h5eed_0a17);
    for (int i = 0; i < 8192; i++) begin ram[i] = 8'h00; exp_ram[i] = 8'h00; end
    #1 rst_ni = 0;
    repeat (3) @(negedge clk);
    chk(cfg_o == 3'd0 && !mem_we, "R1 reset", int'(cfg_o), 0);
    rst_ni = 1;
    @(negedge clk);
    chk(cfg_o == 3'd0 && !mem_we, "R1 after reset", int'(mem_we), 0);

    // R5: protect pin blocks the lock register
    do_cfg(3'd7, 1, "R5 blocked by wp");
    do_cfg(3'd3, 0, "R5 load");
    do_cfg(3'd0, 0, "R5 load none");

    // R2: boundaries of every code
    strap = 2'd2;
    for (int c = 0; c < 8; c++) begin
      do_cfg(3'(c), 0, "R2 set code");
      if (base_of(3'(c)) > 0) begin
        do_start(2'd2, 13'(base_of(3'(c)) - 1));
        do_byte(8'(c + 8'h10), 0, 3'd0, 0, "R2 below region");
      end
      if (base_of(3'(c)) < 8192) begin
        do_start(2'd2, 13'(base_of(3'(c))));
        do_byte(8'(c + 8'h20), 0, 3'd0, 0, "R2 inside region");
      end
    end

    // R3/R4: page wrap with no lock
    do_cfg(3'd0, 0, "R5 clear");
    do_start(2'd2, 13'd8126);
    for (int k = 0; k < 5; k++) do_byte(8'(8'hA0 + k), 0, 3'd0, 0, "R4 page wrap");
    chk(ram[8064] == 8'hA2 && ram[8127] == 8'hA1, "R4 wrapped bytes", int'(ram[8064]), 8'hA2);

    // R6: unselected transfer
    do_start(2'd1, 13'd100);
    for (int k = 0; k < 3; k++) do_byte(8'h55, 0, 3'd0, 0, "R6 unselected");
    chk(ram[100] == 8'h00, "R6 array untouched", int'(ram[100]), 0);

    // R7: lock write coinciding with a byte
    do_start(2'd2, 13'd8190);
    do_byte(8'hC7, 1, 3'd7, 0, "R7 byte uses old lock");
    do_byte(8'hC8, 0, 3'd0, 0, "R7 next byte under new lock");
    chk(cfg_o == 3'd7, "R7 lock updated", int'(cfg_o), 7);
    do_cfg(3'd0, 0, "R5 clear");

    // R8: start and byte together
    xs = 1; selb = 2'd2; saddr = 13'd300; wb = 1; wd = 8'h99;
    @(posedge clk); @(negedge clk);
    xs = 0; wb = 0;
    chk(!mem_we, "R8 coincident byte ignored", int'(mem_we), 0);
    exp_sel = 1; exp_ptr = 13'd300;
    do_byte(8'h3C, 0, 3'd0, 0, "R8 next byte at loaded address");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 2) begin
        do_cfg(3'($urandom_range(0, 7)), bit'($urandom_range(0, 1)), "R5 random lock");
      end else begin
        logic [1:0] s;
        int n;
        strap = 2'($urandom_range(0, 3));
        s = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : strap;
        do_start(s, 13'($urandom_range(0, 8191)));
        n = int'($urandom_range(1, 80));
        for (int k = 0; k < n; k++) begin
          bit ce;
          ce = ($urandom_range(0, 30) == 0);
          do_byte(8'($urandom), ce, 3'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
                  "R3 random byte");
        end
      end
    end

    @(negedge clk);
    mism = 0;
    for (int i = 0; i < 8192; i++) if (ram[i] != exp_ram[i]) mism++;
    chk(mism == 0, "R2 final array image", mism, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule